// File: doc/BRIEF.md
# Phase-Aligned Clock Divider Fanout

This block takes one fast oscillator clock and produces several output banks and one feedback clock. Each output is a divided copy of the oscillator. Every bank has a one-bit ratio select that chooses between a short and a long division. The feedback output has its own select that chooses between two larger divisions. All outputs come from one free-running phase counter, so their rising edges fall on shared oscillator edges. Ratio changes are held back until a safe phase boundary, which keeps glitches and runt pulses off the outputs.

A reference multiplexer picks between a test clock and a second reference clock. In bypass mode that reference drives every output straight through, and the divider chain is skipped. An active-low output enable puts the bank outputs into high impedance. It has no effect on the feedback output. The enable and select inputs are passed through a synchronizer before they are used. A synchronous active-high reset clears the counter and drives every divided output low.

Top module: `divtree_fanout`

## Requirements
- R1: With `bank_sel[i]` at 0, bank i runs at the oscillator frequency divided by 2. With `bank_sel[i]` at 1, it divides by 4. The duty cycle is 50% in both cases.
- R2: With `fb_sel` at 0, the feedback output divides the oscillator by 8. With `fb_sel` at 1, it divides by 12. The duty cycle is 50% in both cases.
- R3: While the synchronized `out_en_n` is 1, every bank output is high impedance. While it is 0, every bank output drives a 0 or a 1.
- R4: The feedback output keeps driving and toggling whatever the value of `out_en_n`.
- R5: Every rising edge of the feedback clock, and every rising edge of a bank running at the long ratio, falls on an oscillator edge where every bank rises.
- R6: Changing a select at any time never shortens or stretches a level. Each high or low level of a bank lasts exactly 1 or 2 oscillator cycles. Each level of the feedback output lasts exactly 4 or 6 cycles.
- R7: While `rst` is high, all divided outputs are low. On the first oscillator edge after `rst` falls, all divided outputs rise together.
- R8: A change on `out_en_n` reaches the bank outputs on the second rising oscillator edge after it is applied, not the first.
- R9: With `bypass_mode` at 1, every output follows `ref_diff_clk` when `ref_pick` is 1 and `ref_test_clk` when `ref_pick` is 0. The bank outputs still obey the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Fast oscillator clock that drives the divider chain |
| rst | input | 1 | Synchronous active-high reset |
| ref_test_clk | input | 1 | Single-ended test reference, used when `ref_pick` is 0 |
| ref_diff_clk | input | 1 | Primary reference, used when `ref_pick` is 1 |
| ref_pick | input | 1 | Reference source select |
| bypass_mode | input | 1 | 1 routes the selected reference to all outputs |
| out_en_n | input | 1 | Active-low bank output enable |
| bank_sel | input | NUM_BANKS | Per-bank ratio select, 0 = short, 1 = long |
| fb_sel | input | 1 | Feedback ratio select, 0 = /8, 1 = /12 |
| bank_clk | output | NUM_BANKS | Bank clock outputs, tri-stated when disabled |
| fb_clk | output | 1 | Feedback clock output, always driven |

## Verification
The assertions are checked on every oscillator cycle:
- the enable pin state, delayed by the synchronizer, matches the bank drive;
- every completed high or low level of each divider has one of the two legal lengths;
- rising edges of the feedback clock and of the banks coincide;
- all outputs launch together just after reset.

Only the bench scenarios can show the remaining behaviour. It measures the actual period and duty of every select combination at the pins. It checks the high-impedance value on the pads and the clean feedback clock while the banks are disabled. It confirms that the bypass path copies the chosen reference. These checks need windows of many cycles or a comparison against asynchronous clocks.

// File: rtl/divtree_pkg.sv
`timescale 1ns/1ps
package divtree_pkg;

   // greatest common divisor, used to derive safe switch boundaries
   function automatic int gcd_f(input int a, input int b);
      int x;
      int y;
      int t;
      x = a;
      y = b;
      while (y != 0) begin
         t = y;
         y = x % y;
         x = t;
      end
      return x;
   endfunction

   function automatic int lcm_f(input int a, input int b);
      return (a / gcd_f(a, b)) * b;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/divtree_sync.sv
`timescale 1ns/1ps
module divtree_sync #(
   parameter int                 WIDTH     = 1,
   parameter int                 STAGES    = 2,
   parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stage [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) stage[0] <= RESET_VAL;
               else     stage[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) stage[s] <= RESET_VAL;
               else     stage[s] <= stage[s-1];
            end
         end
      end
   endgenerate

   assign q = stage[STAGES-1];

endmodule

// File: rtl/divtree_phase.sv
`timescale 1ns/1ps
module divtree_phase #(
   parameter int PERIOD = 24,
   parameter int PW     = 5
) (
   input  logic          clk,
   input  logic          rst,
   output logic [PW-1:0] phase
);

   localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

   always_ff @(posedge clk) begin
      if (rst)                phase <= '0;
      else if (phase == LAST) phase <= '0;
      else                    phase <= phase + 1'b1;
   end

endmodule

// File: rtl/divtree_slot.sv
`timescale 1ns/1ps
module divtree_slot
   import divtree_pkg::*;
#(
   parameter int DIV_LO = 2,
   parameter int DIV_HI = 4,
   parameter int PW     = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [PW-1:0] phase,
   input  logic          sel,
   output logic          div_q
);

   localparam int SWITCH = lcm_f(DIV_LO, DIV_HI);

   logic       at_boundary;
   logic       sel_act;
   logic       eff_sel;
   logic [1:0] lvl;

   // ratio changes only where both ratios restart a period together
   generate
      if (is_pow2(SWITCH)) begin : g_bnd_pow2
         assign at_boundary = (phase[$clog2(SWITCH)-1:0] == '0);
      end else begin : g_bnd_mod
         assign at_boundary = ((int'(phase) % SWITCH) == 0);
      end

      for (genvar r = 0; r < 2; r++) begin : g_ratio
         localparam int N = (r == 0) ? DIV_LO : DIV_HI;
         if (is_pow2(N)) begin : g_pow2
            assign lvl[r] = ~phase[$clog2(N)-1];
         end else begin : g_mod
            assign lvl[r] = ((int'(phase) % N) < (N / 2));
         end
      end
   endgenerate

   assign eff_sel = at_boundary ? sel : sel_act;

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_act <= 1'b0;
         div_q   <= 1'b0;
      end else begin
         if (at_boundary) sel_act <= sel;
         div_q <= lvl[eff_sel];
      end
   end

endmodule

// File: rtl/divtree_fanout.sv
`timescale 1ns/1ps
module divtree_fanout
   import divtree_pkg::*;
#(
   parameter int NUM_BANKS   = 3,
   parameter int BANK_DIV_LO = 2,
   parameter int BANK_DIV_HI = 4,
   parameter int FB_DIV_LO   = 8,
   parameter int FB_DIV_HI   = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 osc_clk,
   input  logic                 rst,
   input  logic                 ref_test_clk,
   input  logic                 ref_diff_clk,
   input  logic                 ref_pick,
   input  logic                 bypass_mode,
   input  logic                 out_en_n,
   input  logic [NUM_BANKS-1:0] bank_sel,
   input  logic                 fb_sel,
   output wire  [NUM_BANKS-1:0] bank_clk,
   output logic                 fb_clk
);

   localparam int PERIOD = lcm_f(lcm_f(BANK_DIV_LO, BANK_DIV_HI), lcm_f(FB_DIV_LO, FB_DIV_HI));
   localparam int PW     = $clog2(PERIOD);
   localparam int CW     = NUM_BANKS + 2;

   generate
      if (NUM_BANKS < 1) begin : g_err_banks
         $error("divtree_fanout: NUM_BANKS must be at least 1");
      end
      if ((BANK_DIV_LO % 2) != 0 || (BANK_DIV_HI % 2) != 0 ||
          (FB_DIV_LO % 2) != 0   || (FB_DIV_HI % 2) != 0) begin : g_err_even
         $error("divtree_fanout: every ratio must be even for a 50%% duty");
      end
      if (BANK_DIV_LO < 2 || FB_DIV_LO < 2) begin : g_err_small
         $error("divtree_fanout: ratios must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_err_sync
         $error("divtree_fanout: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [CW-1:0]        ctl_raw;
   logic [CW-1:0]        ctl_q;
   logic [PW-1:0]        phase;
   logic [NUM_BANKS-1:0] bank_div;
   logic [NUM_BANKS-1:0] bank_src;
   logic                 fb_div;
   logic                 ref_clk;
   logic                 bank_drive;

   assign ctl_raw = {out_en_n, fb_sel, bank_sel};

   divtree_sync #(
      .WIDTH     (CW),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL ('0)
   ) u_sync (
      .clk (osc_clk),
      .rst (rst),
      .d   (ctl_raw),
      .q   (ctl_q)
   );

   divtree_phase #(
      .PERIOD (PERIOD),
      .PW     (PW)
   ) u_phase (
      .clk   (osc_clk),
      .rst   (rst),
      .phase (phase)
   );

   assign ref_clk    = ref_pick ? ref_diff_clk : ref_test_clk;
   assign bank_drive = ~ctl_q[CW-1];

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         divtree_slot #(
            .DIV_LO (BANK_DIV_LO),
            .DIV_HI (BANK_DIV_HI),
            .PW     (PW)
         ) u_slot (
            .clk   (osc_clk),
            .rst   (rst),
            .phase (phase),
            .sel   (ctl_q[b]),
            .div_q (bank_div[b])
         );
         assign bank_src[b] = bypass_mode ? ref_clk : bank_div[b];
         assign bank_clk[b] = bank_drive ? bank_src[b] : 1'bz;
      end
   endgenerate

   divtree_slot #(
      .DIV_LO (FB_DIV_LO),
      .DIV_HI (FB_DIV_HI),
      .PW     (PW)
   ) u_fb_slot (
      .clk   (osc_clk),
      .rst   (rst),
      .phase (phase),
      .sel   (ctl_q[NUM_BANKS]),
      .div_q (fb_div)
   );

   assign fb_clk = bypass_mode ? ref_clk : fb_div;

endmodule

// File: rtl/divtree_fanout_chk.sv
`timescale 1ns/1ps
module divtree_fanout_chk #(
   parameter int NUM_BANKS   = 3,
   parameter int BANK_DIV_LO = 2,
   parameter int BANK_DIV_HI = 4,
   parameter int FB_DIV_LO   = 8,
   parameter int FB_DIV_HI   = 12,
   parameter int SYNC_STAGES = 2
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 out_en_n,
   input logic                 bank_drive,
   input logic [NUM_BANKS-1:0] bank_div,
   input logic                 fb_div
);

   logic [7:0]           since_rst;
   logic [7:0]           bank_run [NUM_BANKS];
   logic [NUM_BANKS-1:0] bank_prev;
   logic [NUM_BANKS-1:0] bank_seen;
   logic [7:0]           fb_run;
   logic                 fb_prev;
   logic                 fb_seen;

   always_ff @(posedge clk) begin
      if (rst) since_rst <= '0;
      else if (since_rst != 8'hFF) since_rst <= since_rst + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         fb_run  <= '0;
         fb_prev <= 1'b0;
         fb_seen <= 1'b0;
      end else begin
         fb_prev <= fb_div;
         if (fb_div != fb_prev) begin
            fb_run  <= 8'd1;
            fb_seen <= 1'b1;
         end else if (fb_run != 8'hFF) begin
            fb_run <= fb_run + 1'b1;
         end
      end
   end

   // R3: bank drive follows the enable pin after the synchronizer delay
   p_drive_off_r3: assert property (@(posedge clk) disable iff (rst)
      ((since_rst >= 8'(SYNC_STAGES)) && $past(out_en_n, SYNC_STAGES)) |-> !bank_drive);

   p_drive_on_r3: assert property (@(posedge clk) disable iff (rst)
      ((since_rst >= 8'(SYNC_STAGES)) && !$past(out_en_n, SYNC_STAGES)) |-> bank_drive);

   // R6 and R2: feedback levels have one of the two legal lengths
   p_fb_run_r6: assert property (@(posedge clk) disable iff (rst)
      (fb_seen && (fb_div != fb_prev)) |->
         ((fb_run == 8'(FB_DIV_LO / 2)) || (fb_run == 8'(FB_DIV_HI / 2))));

   // R5: feedback rising edge coincides with a rising edge on every bank
   p_edges_aligned_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(fb_div) |-> ((bank_div & ~$past(bank_div)) == {NUM_BANKS{1'b1}}));

   // R7: all dividers launch together on the first edge after reset
   p_reset_launch_r7: assert property (@(posedge clk) disable iff (rst)
      ($past(rst, 2) && !$past(rst)) |-> (fb_div && (&bank_div)));

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
         always_ff @(posedge clk) begin
            if (rst) begin
               bank_run[b]  <= '0;
               bank_prev[b] <= 1'b0;
               bank_seen[b] <= 1'b0;
            end else begin
               bank_prev[b] <= bank_div[b];
               if (bank_div[b] != bank_prev[b]) begin
                  bank_run[b]  <= 8'd1;
                  bank_seen[b] <= 1'b1;
               end else if (bank_run[b] != 8'hFF) begin
                  bank_run[b] <= bank_run[b] + 1'b1;
               end
            end
         end

         // R6 and R1: bank levels have one of the two legal lengths
         p_bank_run_r6: assert property (@(posedge clk) disable iff (rst)
            (bank_seen[b] && (bank_div[b] != bank_prev[b])) |->
               ((bank_run[b] == 8'(BANK_DIV_LO / 2)) || (bank_run[b] == 8'(BANK_DIV_HI / 2))));
      end
   endgenerate

endmodule

bind divtree_fanout divtree_fanout_chk #(
   .NUM_BANKS   (NUM_BANKS),
   .BANK_DIV_LO (BANK_DIV_LO),
   .BANK_DIV_HI (BANK_DIV_HI),
   .FB_DIV_LO   (FB_DIV_LO),
   .FB_DIV_HI   (FB_DIV_HI),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk        (osc_clk),
   .rst        (rst),
   .out_en_n   (out_en_n),
   .bank_drive (bank_drive),
   .bank_div   (bank_div),
   .fb_div     (fb_div)
);

// File: tb/divtree_fanout_bench.sv
`timescale 1ns/1ps
module divtree_fanout_bench;

   localparam int NB     = 3;
   localparam int B_LO   = 2;
   localparam int B_HI   = 4;
   localparam int F_LO   = 8;
   localparam int F_HI   = 12;
   localparam int WINDOW = 48;

   logic          osc_clk = 1'b0;
   logic          rst = 1'b1;
   logic          ref_test_clk = 1'b0;
   logic          ref_diff_clk = 1'b0;
   logic          ref_pick = 1'b0;
   logic          bypass_mode = 1'b0;
   logic          out_en_n = 1'b0;
   logic [NB-1:0] bank_sel = '0;
   logic          fb_sel = 1'b0;
   wire  [NB-1:0] bank_clk;
   logic          fb_clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   divtree_fanout #(
      .NUM_BANKS   (NB),
      .BANK_DIV_LO (B_LO),
      .BANK_DIV_HI (B_HI),
      .FB_DIV_LO   (F_LO),
      .FB_DIV_HI   (F_HI),
      .SYNC_STAGES (2)
   ) u_divtree_fanout (
      .osc_clk      (osc_clk),
      .rst          (rst),
      .ref_test_clk (ref_test_clk),
      .ref_diff_clk (ref_diff_clk),
      .ref_pick     (ref_pick),
      .bypass_mode  (bypass_mode),
      .out_en_n     (out_en_n),
      .bank_sel     (bank_sel),
      .fb_sel       (fb_sel),
      .bank_clk     (bank_clk),
      .fb_clk       (fb_clk)
   );

   always #2.5 osc_clk = ~osc_clk;
   initial begin #1; forever #20 ref_test_clk = ~ref_test_clk; end
   initial begin #3; forever #15 ref_diff_clk = ~ref_diff_clk; end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int k = 0; k < n; k++) @(negedge osc_clk);
   endtask

   // measure rises and high samples over a window of whole periods
   task automatic measure_sweep(input logic [NB-1:0] bs, input logic fs);
      int rises [NB+1];
      int highs [NB+1];
      int misalign;
      logic [NB:0] prev;
      logic [NB:0] cur;
      misalign = 0;
      for (int i = 0; i <= NB; i++) begin rises[i] = 0; highs[i] = 0; end
      @(negedge osc_clk);
      prev = {fb_clk, bank_clk};
      for (int k = 0; k < WINDOW; k++) begin
         @(negedge osc_clk);
         cur = {fb_clk, bank_clk};
         for (int i = 0; i <= NB; i++) begin
            if (cur[i] && !prev[i]) rises[i]++;
            if (cur[i]) highs[i]++;
         end
         // R5: fb rise or any long-ratio bank rise needs every bank rising
         for (int i = 0; i <= NB; i++) begin
            if (cur[i] && !prev[i] && (i == NB || bs[i])) begin
               if ((cur[NB-1:0] & ~prev[NB-1:0]) != {NB{1'b1}}) misalign++;
            end
         end
         prev = cur;
      end
      for (int i = 0; i < NB; i++) begin
         int n;
         n = bs[i] ? B_HI : B_LO;
         check(rises[i] == WINDOW / n, "R1 bank rises", rises[i], WINDOW / n);
         check(highs[i] == WINDOW / 2, "R1 bank duty", highs[i], WINDOW / 2);
      end
      begin
         int n;
         n = fs ? F_HI : F_LO;
         check(rises[NB] == WINDOW / n, "R2 feedback rises", rises[NB], WINDOW / n);
         check(highs[NB] == WINDOW / 2, "R2 feedback duty", highs[NB], WINDOW / 2);
      end
      check(misalign == 0, "R5 edge alignment", misalign, 0);
   endtask

   initial begin
      logic [7:0] lfsr;
      int bad_runs [NB+1];
      int run_len [NB+1];
      bit seen [NB+1];
      logic [NB:0] prev;
      logic [NB:0] cur;
      int zcnt;
      int mism;
      int frises;

      // reset state (R7)
      wait_neg(4);
      check(bank_clk == '0, "R7 banks low in reset", int'(bank_clk), 0);
      check(fb_clk == 1'b0, "R7 feedback low in reset", int'(fb_clk), 0);
      rst = 1'b0;
      @(negedge osc_clk);
      check(bank_clk == {NB{1'b1}}, "R7 banks launch together", int'(bank_clk), (1 << NB) - 1);
      check(fb_clk == 1'b1, "R7 feedback launches with banks", int'(fb_clk), 1);

      // full sweep of select combinations (R1, R2, R5)
      for (int c = 0; c < (1 << (NB + 1)); c++) begin
         bank_sel = c[NB-1:0];
         fb_sel   = c[NB];
         wait_neg(70);
         measure_sweep(c[NB-1:0], c[NB]);
      end

      // selects changing at arbitrary times (R6)
      lfsr = 8'h5B;
      for (int i = 0; i <= NB; i++) begin bad_runs[i] = 0; run_len[i] = 0; seen[i] = 0; end
      @(negedge osc_clk);
      prev = {fb_clk, bank_clk};
      for (int k = 0; k < 3000; k++) begin
         @(negedge osc_clk);
         cur = {fb_clk, bank_clk};
         for (int i = 0; i <= NB; i++) begin
            if (cur[i] != prev[i]) begin
               if (seen[i]) begin
                  if (i == NB) begin
                     if (run_len[i] != F_LO / 2 && run_len[i] != F_HI / 2) bad_runs[i]++;
                  end else begin
                     if (run_len[i] != B_LO / 2 && run_len[i] != B_HI / 2) bad_runs[i]++;
                  end
               end
               seen[i] = 1'b1;
               run_len[i] = 1;
            end else begin
               run_len[i]++;
            end
         end
         prev = cur;
         if ((k % 5) == 2) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            bank_sel = lfsr[NB-1:0];
            fb_sel   = lfsr[NB];
         end
      end
      for (int i = 0; i <= NB; i++)
         check(bad_runs[i] == 0, "R6 no runt or stretched level", bad_runs[i], 0);

      // enable timing and tri-state (R8, R3, R4)
      bank_sel = '0;
      fb_sel   = 1'b0;
      wait_neg(40);
      out_en_n = 1'b1;
      @(negedge osc_clk);
      check(bank_clk !== {NB{1'bz}}, "R8 still driven after one edge", 0, 1);
      @(negedge osc_clk);
      zcnt = 0;
      for (int i = 0; i < NB; i++) if (bank_clk[i] === 1'bz) zcnt++;
      check(zcnt == NB, "R8 disabled after two edges", zcnt, NB);
      zcnt = 0;
      frises = 0;
      prev[0] = fb_clk;
      for (int k = 0; k < WINDOW; k++) begin
         @(negedge osc_clk);
         for (int i = 0; i < NB; i++) if (bank_clk[i] === 1'bz) zcnt++;
         if (fb_clk && !prev[0]) frises++;
         prev[0] = fb_clk;
      end
      check(zcnt == NB * WINDOW, "R3 banks high impedance", zcnt, NB * WINDOW);
      check(frises == WINDOW / F_LO, "R4 feedback toggles while disabled", frises, WINDOW / F_LO);
      out_en_n = 1'b0;
      @(negedge osc_clk);
      zcnt = 0;
      for (int i = 0; i < NB; i++) if (bank_clk[i] === 1'bz) zcnt++;
      check(zcnt == NB, "R8 still disabled after one edge", zcnt, NB);
      @(negedge osc_clk);
      zcnt = 0;
      for (int i = 0; i < NB; i++) if (bank_clk[i] === 1'b0 || bank_clk[i] === 1'b1) zcnt++;
      check(zcnt == NB, "R3 banks driven when enabled", zcnt, NB);

      // bypass routes the chosen reference (R9)
      bypass_mode = 1'b1;
      for (int p = 0; p < 2; p++) begin
         ref_pick = p[0];
         mism = 0;
         wait_neg(2);
         for (int k = 0; k < 200; k++) begin
            @(negedge osc_clk);
            for (int i = 0; i < NB; i++)
               if (bank_clk[i] !== (p[0] ? ref_diff_clk : ref_test_clk)) mism++;
            if (fb_clk !== (p[0] ? ref_diff_clk : ref_test_clk)) mism++;
         end
         check(mism == 0, "R9 bypass follows reference", mism, 0);
      end
      out_en_n = 1'b1;
      wait_neg(3);
      zcnt = 0;
      mism = 0;
      for (int k = 0; k < 200; k++) begin
         @(negedge osc_clk);
         for (int i = 0; i < NB; i++) if (bank_clk[i] === 1'bz) zcnt++;
         if (fb_clk !== ref_diff_clk) mism++;
      end
      check(zcnt == NB * 200, "R9 bypass obeys enable", zcnt, NB * 200);
      check(mism == 0, "R9 R4 feedback bypass while disabled", mism, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge osc_clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule